// File: doc/BRIEF.md
# Period-Match Timer with Prescaler and Postscaler

This block is an 8-bit up-counter that counts to a programmable period and then restarts from zero. Its count advances on a slow tick derived from the system clock. A fixed divide-by-four stage and a selectable prescaler slow the tick. Each time the counter reaches the period, a match event occurs. The raw match event is exported as a one-cycle strobe, which a serial port can use as its shift-clock source. The match events also feed a postscaler. The postscaler output sets a sticky interrupt flag.

Software controls the block through a small register bus. Writes take effect on the clock edge at which they are presented. Reads are combinational from the selected address. The address map is: 0 = count, 1 = period, 2 = control, 3 = flag. In the control word, bits 1:0 select the prescale ratio, bit 2 enables counting, and bits 6:3 hold the postscale ratio minus one. In the flag register, bit 0 is the interrupt flag.

Top module: `period_timer`

## Requirements
- R1: While enabled, the count advances once every 4×N system clocks. N is 1 for control bits 1:0 = 00, 4 for 01, and 16 for both 10 and 11. The first advance comes 4×N clocks after the write that last restarted the dividers.
- R2: The count rises from 00h toward the period value. At the advance that follows count == period, the count becomes 00h instead of period+1.
- R3: After reset, the count is 00h, the period is FFh, the control word is 00h and the flag is 0. The count, period and control registers read back the values written to addresses 0, 1 and 2.
- R4: Control bits 6:3 hold M−1, where M is 1 to 16. The flag is set at every M-th match event counted since the dividers were last restarted. The flag rises at the same clock edge as the strobe of that match.
- R5: While control bit 2 is 0, the count holds its value and no match occurs. A bus write to address 0 still loads the count.
- R6: A bus write to address 0 or address 2 restarts the divide-by-four, prescale and postscale state from zero.
- R7: A write to the control word leaves the count unchanged.
- R8: The baud strobe is high for exactly one clock after each match. It rises at the edge where the count returns to 00h.
- R9: The flag (address 3, bit 0) stays set until a bus write to address 3 with data bit 0 = 1. A write with bit 0 = 0 leaves the flag as it is. If a set and a clear fall at the same edge, the flag ends set.
- R10: If the period is below the current count, the count keeps rising through FFh to 00h without a match event. It then matches on reaching the period.
- R11: Bit 7 of the control word always reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe; a write happens at each edge where it is high |
| bus_addr | input | 2 | Register select: 0 count, 1 period, 2 control, 3 flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| baud_strobe | output | 1 | One-cycle pulse per match event, before the postscaler |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The properties assume that the bus inputs are stable around the active edge. They also assume that a write to address 3 clears the flag only when data bit 0 is 1. The one-cycle strobe property relies on match events being at least four clocks apart, which the divide-by-four stage guarantees. The bench changes bus signals only at falling edges and holds bus_wr for exactly one rising edge per write. Before starting a scenario, it disables counting so that no stray tick falls between setup writes.

// File: rtl/tmr_pkg.sv
// Shared definitions for the period-match timer.
// Assumes a 2-bit register select on the bus.
package tmr_pkg;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_FLAG   = 2'd3
    } reg_sel_e;

    // Map the 2-bit prescale code to its divide ratio; codes 10 and 11 share 1:16.
    function automatic int unsigned presc_ratio(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/tmr_prescaler.sv
// Combined divide-by-QUARTER and selectable prescaler.
// Emits a single-cycle advance tick every QUARTER*ratio clocks while run is high.
// Assumes restart comes only from bus writes; a restart suppresses the tick in its own cycle.
module tmr_prescaler #(
    parameter int QUARTER   = 4,
    parameter int MAX_RATIO = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    import tmr_pkg::*;

    localparam int LIMIT_MAX = QUARTER * MAX_RATIO;
    localparam int DIV_W     = $clog2(LIMIT_MAX);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] last_q;

    // Terminal value of the divider for the selected ratio.
    always_comb begin
        last_q = DIV_W'(QUARTER * presc_ratio(sel) - 1);
    end

    // Tick fires on the terminal value, never in a restart cycle.
    always_comb begin
        tick = run && !restart && (div_q == last_q);
    end

    // Divider state: cleared by reset or restart, frozen while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            div_q <= '0;
        end else if (run) begin
            if (div_q == last_q) div_q <= '0;
            else                 div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_counter.sv
// Period-match up-counter.
// It advances on tick and wraps to zero on the tick after count equals period.
// A load has priority over the tick; the caller guarantees that tick is low during a load.
module tmr_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             match
);

    // A match is an advance taken while the count equals the period.
    always_comb begin
        match = tick && !load && (count == period);
    end

    // Count register: load, wrap on match, or natural increment (FFh rolls to 00h).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick) begin
            if (count == period) count <= '0;
            else                 count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_postscaler.sv
// Match-event postscaler.
// Fires on every (ratio_m1+1)-th match since the last restart.
// Assumes no match arrives in a restart cycle.
module tmr_postscaler #(
    parameter int PS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            match,
    input  logic [PS_W-1:0] ratio_m1,
    output logic            fire
);

    logic [PS_W-1:0] ev_q;

    // Fire when the event that completes the ratio arrives.
    always_comb begin
        fire = match && !restart && (ev_q == ratio_m1);
    end

    // Event counter: cleared by reset, restart or fire.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            ev_q <= '0;
        end else if (match) begin
            if (ev_q == ratio_m1) ev_q <= '0;
            else                  ev_q <= ev_q + 1'b1;
        end
    end

endmodule

// File: rtl/period_timer.sv
// Top of the period-match timer.
// It holds the period, control and flag registers, decodes bus writes and muxes reads.
// Assumes a single-cycle write per bus_wr pulse; reads are combinational.
// Control layout: [1:0] prescale code, [2] enable, [3+PS_W-1:3] postscale ratio minus one.
module period_timer #(
    parameter int CNT_W   = 8,
    parameter int QUARTER = 4,
    parameter int PS_W    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             baud_strobe,
    output logic             irq_flag
);
    import tmr_pkg::*;

    localparam int CTRL_W = 3 + PS_W;
    localparam int EN_BIT = 2;
    localparam int PS_LO  = 3;
    localparam int PS_HI  = PS_LO + PS_W - 1;

    logic [CNT_W-1:0]  period_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              flag_q;
    logic              strobe_q;
    logic [CNT_W-1:0]  count;
    logic              wr_count, wr_period, wr_ctrl, wr_flag;
    logic              restart, tick, match, fire, clr_req;

    // Write decode per register.
    always_comb begin
        wr_count  = bus_wr && (reg_sel_e'(bus_addr) == SEL_COUNT);
        wr_period = bus_wr && (reg_sel_e'(bus_addr) == SEL_PERIOD);
        wr_ctrl   = bus_wr && (reg_sel_e'(bus_addr) == SEL_CTRL);
        wr_flag   = bus_wr && (reg_sel_e'(bus_addr) == SEL_FLAG);
        restart   = wr_count || wr_ctrl;
        clr_req   = wr_flag && bus_wdata[0];
    end

    tmr_prescaler #(.QUARTER(QUARTER), .MAX_RATIO(16)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q[EN_BIT]),
        .restart (restart),
        .sel     (ctrl_q[1:0]),
        .tick    (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wr_count),
        .load_val (bus_wdata),
        .tick     (tick),
        .period   (period_q),
        .count    (count),
        .match    (match)
    );

    tmr_postscaler #(.PS_W(PS_W)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .match    (match),
        .ratio_m1 (ctrl_q[PS_HI:PS_LO]),
        .fire     (fire)
    );

    // Period and control registers with their reset defaults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= '1;
            ctrl_q   <= '0;
        end else begin
            if (wr_period) period_q <= bus_wdata;
            if (wr_ctrl)   ctrl_q   <= bus_wdata[CTRL_W-1:0];
        end
    end

    // Sticky flag (set beats clear) and the registered match strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= match;
            if (fire)         flag_q <= 1'b1;
            else if (clr_req) flag_q <= 1'b0;
        end
    end

    // Read mux; unused upper bits read as zero.
    always_comb begin
        case (reg_sel_e'(bus_addr))
            SEL_COUNT:  bus_rdata = count;
            SEL_PERIOD: bus_rdata = period_q;
            SEL_CTRL:   bus_rdata = CNT_W'(ctrl_q);
            default:    bus_rdata = CNT_W'(flag_q);
        endcase
    end

    assign baud_strobe = strobe_q;
    assign irq_flag    = flag_q;

endmodule

// File: rtl/period_timer_chk.sv
// Property checker for period_timer, attached by bind.
// It observes the bus, the outputs, the count and the enable bit.
module period_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic             wdata0,
    input logic             baud_strobe,
    input logic             irq_flag,
    input logic [CNT_W-1:0] count,
    input logic             enable
);

    // R8: strobe lasts one cycle (matches are at least four clocks apart).
    a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        baud_strobe |=> !baud_strobe);

    // R2: a strobe only appears with the count just wrapped to zero.
    a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        baud_strobe |-> (count == '0));

    // R5: with enable low and no count write, the count is frozen.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !(bus_wr && bus_addr == 2'd0)) |=> $stable(count));

    // R7: a control write leaves the count unchanged.
    a_r7_ctrl_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd2) |=> $stable(count));

    // R9: the flag stays set unless a clear is requested.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !(bus_wr && bus_addr == 2'd3 && wdata0)) |=> irq_flag);

    // R4: the flag only rises together with a match strobe.
    a_r4_flag_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> baud_strobe);

endmodule

bind period_timer period_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .wdata0      (bus_wdata[0]),
    .baud_strobe (baud_strobe),
    .irq_flag    (irq_flag),
    .count       (count),
    .enable      (ctrl_q[2])
);

// File: tb/period_timer_bench.sv
// Directed bench for period_timer: one task per scenario, each checking its own results.
module period_timer_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       baud_strobe;
    logic       irq_flag;

    int total = 0;
    int bad = 0;
    int strobes = 0;
    bit done = 1'b0;

    period_timer u_period_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .baud_strobe (baud_strobe),
        .irq_flag    (irq_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Count strobe cycles shortly after each rising edge.
    always @(posedge clk) begin
        #1;
        if (rst_n && baud_strobe) strobes++;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input int exp);
        logic [7:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    // Stop counting and set period and count; leaves the flag cleared.
    task automatic setup(input logic [7:0] per, input logic [7:0] cnt);
        wr(2'd2, 8'h00);
        wr(2'd1, per);
        wr(2'd0, cnt);
        wr(2'd3, 8'h01);
        strobes = 0;
    endtask

    task automatic t_reset();
        rd_check("R3 count reset", 2'd0, 8'h00);
        rd_check("R3 period reset", 2'd1, 8'hFF);
        rd_check("R3 ctrl reset", 2'd2, 8'h00);
        rd_check("R3 flag reset", 2'd3, 8'h00);
        check("R3 strobe reset", baud_strobe, 0);
        check("R3 irq reset", irq_flag, 0);
        wr(2'd1, 8'hA5);
        rd_check("R3 period readback", 2'd1, 8'hA5);
    endtask

    task automatic t_basic();
        setup(8'd5, 8'd0);
        wr(2'd2, 8'h04);
        step(12);
        rd_check("R1 count after 12 clocks at 1:1", 2'd0, 3);
        step(11);
        rd_check("R2 count at period", 2'd0, 5);
        check("R2 no strobe before wrap", strobes, 0);
        step(1);
        rd_check("R2 wrap to zero", 2'd0, 0);
        check("R8 strobe high at wrap", baud_strobe, 1);
        check("R8 one strobe counted", strobes, 1);
        step(1);
        check("R8 strobe drops after one cycle", baud_strobe, 0);
    endtask

    task automatic t_prescale();
        setup(8'hFF, 8'd0);
        wr(2'd2, 8'h05);
        step(48);
        rd_check("R1 ratio 1:4", 2'd0, 3);
        setup(8'hFF, 8'd0);
        wr(2'd2, 8'h06);
        step(127);
        rd_check("R1 ratio 1:16 before edge", 2'd0, 1);
        step(1);
        rd_check("R1 ratio 1:16", 2'd0, 2);
        setup(8'hFF, 8'd0);
        wr(2'd2, 8'h07);
        step(63);
        rd_check("R1 code 11 before edge", 2'd0, 0);
        step(1);
        rd_check("R1 code 11 equals 1:16", 2'd0, 1);
    endtask

    task automatic t_enable();
        setup(8'hFF, 8'd0);
        wr(2'd2, 8'h04);
        step(10);
        wr(2'd2, 8'h00);
        step(100);
        rd_check("R5 count held while disabled", 2'd0, 2);
        check("R5 no strobe while disabled", strobes, 0);
        wr(2'd0, 8'h33);
        rd_check("R5 load works while disabled", 2'd0, 8'h33);
    endtask

    task automatic t_ctrl_keep();
        setup(8'hFF, 8'h42);
        wr(2'd2, 8'h06);
        rd_check("R7 count after ctrl write", 2'd0, 8'h42);
        wr(2'd2, 8'h04);
        rd_check("R7 count after second ctrl write", 2'd0, 8'h42);
    endtask

    task automatic t_restart();
        setup(8'hFF, 8'd0);
        wr(2'd2, 8'h06);
        step(40);
        wr(2'd0, 8'h10);
        step(63);
        rd_check("R6 count write restarts prescale", 2'd0, 8'h10);
        step(1);
        rd_check("R6 first tick after count write", 2'd0, 8'h11);
        step(30);
        wr(2'd2, 8'h06);
        step(63);
        rd_check("R6 ctrl write restarts prescale", 2'd0, 8'h11);
        step(1);
        rd_check("R6 first tick after ctrl write", 2'd0, 8'h12);
        setup(8'd0, 8'd0);
        wr(2'd2, 8'h14);
        step(9);
        wr(2'd2, 8'h14);
        step(11);
        check("R6 postscale restarted", irq_flag, 0);
        step(1);
        check("R6 flag after three fresh matches", irq_flag, 1);
    endtask

    task automatic t_post();
        setup(8'd1, 8'd0);
        wr(2'd2, 8'h14);
        step(23);
        check("R4 flag clear before third match", irq_flag, 0);
        check("R4 two matches so far", strobes, 2);
        step(1);
        check("R4 flag on third match (1:3)", irq_flag, 1);
        check("R4 flag with strobe", baud_strobe, 1);
        setup(8'd0, 8'd0);
        wr(2'd2, 8'h7C);
        step(63);
        check("R4 1:16 before sixteenth match", irq_flag, 0);
        step(1);
        check("R4 1:16 on sixteenth match", irq_flag, 1);
        setup(8'd0, 8'd0);
        wr(2'd2, 8'h04);
        step(4);
        check("R4 1:1 on first match", irq_flag, 1);
    endtask

    task automatic t_flag();
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h00);
        rd_check("R9 write of 0 keeps flag", 2'd3, 1);
        wr(2'd3, 8'h01);
        rd_check("R9 write of 1 clears flag", 2'd3, 0);
        check("R9 irq port cleared", irq_flag, 0);
        setup(8'd0, 8'd0);
        wr(2'd2, 8'h04);
        step(7);
        wr(2'd3, 8'h01);
        check("R9 set beats simultaneous clear", irq_flag, 1);
        wr(2'd2, 8'h00);
        wr(2'd3, 8'h01);
        check("R9 flag cleared afterwards", irq_flag, 0);
    endtask

    task automatic t_below();
        setup(8'hFF, 8'hFE);
        wr(2'd1, 8'h10);
        wr(2'd2, 8'h04);
        step(4);
        rd_check("R10 count passes period upward", 2'd0, 8'hFF);
        step(4);
        rd_check("R10 count rolls to 00", 2'd0, 8'h00);
        check("R10 no strobe on rollover", strobes, 0);
        check("R10 no flag on rollover", irq_flag, 0);
        step(67);
        rd_check("R10 count reaches period", 2'd0, 8'h10);
        check("R10 still no strobe", strobes, 0);
        step(1);
        check("R10 match after rollover", strobes, 1);
        rd_check("R10 wrap after match", 2'd0, 8'h00);
    endtask

    task automatic t_ctrl_read();
        wr(2'd2, 8'hFF);
        rd_check("R11 bit 7 reads zero", 2'd2, 8'h7F);
        wr(2'd2, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_basic();
        t_prescale();
        t_enable();
        t_ctrl_keep();
        t_restart();
        t_post();
        t_flag();
        t_below();
        t_ctrl_read();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule